// File: doc/BRIEF.md
# Eight-Level Vectored Priority Interrupt Controller

This block collects up to eight interrupt request lines and keeps each request in a latch. A host-programmed mask hides chosen levels. A fixed-priority resolver compares the pending levels against the levels already being serviced, and raises a single interrupt output toward the processor. The processor answers with two acknowledge pulses. The first pulse picks the winning level and marks it as in service. The second pulse drives an 8-bit vector onto the data bus. The vector is a programmed base in the upper bits, with the winning level number in the low three bits.

The host programs and inspects the block through a small register port. The port has a chip select, read and write strobes, one address bit and an 8-bit data bus. After a start-up word sequence, the host can load the mask and read back the pending or in-service set. It can retire service with a specific or a non-specific end-of-service command. It can also run a software poll, which acknowledges without any bus cycle. A trigger-mode bit selects edge capture or level capture. In level mode, a line that is still held when service ends asks for service again.

All strobes are active low. They are sampled on the rising clock edge, and each low cycle counts as one access. Request lines are assumed to be synchronous to the clock.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A write at address 0 with data bit 4 set starts initialization. It clears the mask, in-service and pending sets, and selects the pending set for status reads. The next address-1 write sets the vector base from data bits 7:3. A further address-1 write is swallowed only when bit 0 of the start word was set. The interrupt output stays low until this sequence has completed.
- R2: In edge mode (start-word bit 3 clear), a rising request line sets its pending bit from the next clock. The bit stays set after the line drops. A mask bit of 1 hides its level from the interrupt output.
- R3: Priority is fixed, with level 0 highest. The interrupt output is high only when some unmasked pending level is numerically lower than every level in service.
- R4: The first acknowledge pulse sets the in-service bit of the winning level. In edge mode it also clears that level's pending bit. The second pulse drives dout = {base[7:3], level} with dout_oe high.
- R5: If no level wins at the first acknowledge, the second pulse leaves dout_oe low and no in-service bit is set.
- R6: A command byte of 0x20 at address 0 clears the in-service bit of the lowest-numbered level in service.
- R7: A command byte of 0x60 OR'd with level n, at address 0, clears in-service bit n only.
- R8: In level mode (start-word bit 3 set), a pending bit follows a high line and is not cleared by an acknowledge. At end of service it is cleared only if the line is low, so a held line requests again.
- R9: An address-0 write with bits 3 and 2 set (and bit 4 clear) is a poll, and it moves the winner into service. The next address-0 read returns 0x80 OR'd with the level number, or 0x00 if nothing won. Later reads return status again.
- R10: An address-0 write with bits 3 and 1 set (bit 4 clear) selects the status read: bit 0 = 1 picks the in-service set, 0 picks the pending set. Reads at address 0 return the selection. Address-1 writes after initialization load the mask, and address-1 reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Register port select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or vector |
| dout_oe | output | 1 | High while dout carries valid read data or a vector |
| irq | input | 8 | Request lines, active high |
| inta_n | input | 1 | Acknowledge strobe, active low |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a level-mode line that is still held when its service ends. Reaching it needs a complete level-mode re-initialization, a grant, and an end-of-service command issued while the line is still driven. The stimulus then checks that the interrupt output rises again without any new edge. A second hard case is a nested grant, where a higher level pre-empts a level already in service. It is reached by raising a low-priority line during service, which must stay quiet, then adding level 0, which must break through. Both service bits are then read back before they are retired one at a time.

// File: rtl/irq_vec_pkg.sv
// Shared types and command codes for the vectored interrupt controller.
// Assumes an 8-bit host data bus.
package irq_vec_pkg;
    localparam int DATA_W = 8;

    // Start-up sequence position
    typedef enum logic [1:0] {
        INIT_WAIT_START,
        INIT_WAIT_BASE,
        INIT_WAIT_EXTRA,
        INIT_READY
    } init_state_t;

    // Which set an address-0 status read returns
    typedef enum logic {
        SEL_PEND,
        SEL_SERV
    } stat_sel_t;

    // End-of-service command codes in data bits 7:5
    localparam logic [2:0] CMD_EOS_ANY = 3'b001;
    localparam logic [2:0] CMD_EOS_ONE = 3'b011;
endpackage

// File: rtl/irq_req_latch.sv
// Request latch bank: captures each line on a rising edge (edge mode) or while
// high (level mode). Clears on grant in edge mode, and at end of service when the
// line is low in level mode. Assumes lines are synchronous to clk.
module irq_req_latch #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq,
    input  logic             level_mode,
    input  logic             clear_all,
    input  logic [N_IRQ-1:0] take_mask,
    input  logic [N_IRQ-1:0] eos_mask,
    output logic [N_IRQ-1:0] pend
);
    logic [N_IRQ-1:0] irq_q;
    logic [N_IRQ-1:0] capture;
    logic [N_IRQ-1:0] drop;
    logic [N_IRQ-1:0] pend_d;

    // Previous line sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq;
    end

    // Next pending value: capture wins over drop
    always_comb begin
        capture = level_mode ? irq : (irq & ~irq_q);
        drop    = level_mode ? (eos_mask & ~irq) : take_mask;
        pend_d  = clear_all ? '0 : ((pend & ~drop) | capture);
    end

    // Pending register
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_d;
    end

    // Per-line capture and hold checks
    for (genvar i = 0; i < N_IRQ; i++) begin : g_chk
        p_edge_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!level_mode && irq[i] && !irq_q[i] && !clear_all) |=> pend[i]);
        p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (level_mode && pend[i] && irq[i] && !clear_all) |=> pend[i]);
    end
endmodule

// File: rtl/irq_prio_resolve.sv
// Fixed-priority resolver, level 0 highest. Finds the best unmasked pending level
// and the best level in service. Grants only when the pending one outranks every
// level in service. Purely combinational.
module irq_prio_resolve #(
    parameter int N_IRQ = 8,
    localparam int LVL_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] pend,
    input  logic [N_IRQ-1:0] mask,
    input  logic [N_IRQ-1:0] serv,
    output logic             grant_valid,
    output logic [LVL_W-1:0] grant_lvl,
    output logic             serv_valid,
    output logic [LVL_W-1:0] serv_lvl
);
    logic [N_IRQ-1:0] live;
    logic             live_any;
    logic [N_IRQ-1:0] upto;

    // Lowest set bit of each set; scanning downward leaves the lowest
    always_comb begin
        live      = pend & ~mask;
        live_any  = 1'b0;
        grant_lvl = '0;
        serv_valid = 1'b0;
        serv_lvl  = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (live[i]) begin
                live_any  = 1'b1;
                grant_lvl = LVL_W'(i);
            end
            if (serv[i]) begin
                serv_valid = 1'b1;
                serv_lvl   = LVL_W'(i);
            end
        end
        grant_valid = live_any && (!serv_valid || (grant_lvl < serv_lvl));
    end

    // Mask of levels at or above the granted one, used by the checks
    always_comb begin
        upto = '0;
        for (int i = 0; i < N_IRQ; i++) upto[i] = (LVL_W'(i) <= grant_lvl);
    end

    // Granted level is a live request and nothing equal or higher is in service
    always_comb begin
        if (grant_valid) begin
            p_grant_live_r3: assert (live[grant_lvl]);
            p_grant_outranks_r3: assert ((serv & upto) == '0);
        end
    end
endmodule

// File: rtl/irq_host_port.sv
// Host register port decoder: runs the start-up sequence, holds the vector base,
// trigger mode, mask and status select, and issues one-cycle command pulses
// (start, end-of-service, poll). Assumes one write per low strobe cycle.
module irq_host_port
    import irq_vec_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int LVL_W = $clog2(N_IRQ),
    localparam int BASE_W = DATA_W - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    output logic              ready,
    output logic              level_mode,
    output logic [BASE_W-1:0] vec_base,
    output logic [N_IRQ-1:0]  mask,
    output stat_sel_t         stat_sel,
    output logic              start_stb,
    output logic              eos_any,
    output logic              eos_one,
    output logic [LVL_W-1:0]  eos_lvl,
    output logic              poll_stb
);
    init_state_t state;
    logic        want_extra;
    logic        is_cmd2;
    logic        is_cmd3;

    // Decode address-0 writes into command pulses
    always_comb begin
        ready     = (state == INIT_READY);
        start_stb = wr_stb && !a0 && din[4];
        is_cmd3   = wr_stb && !a0 && !din[4] && din[3] && ready;
        is_cmd2   = wr_stb && !a0 && !din[4] && !din[3] && ready;
        eos_any   = is_cmd2 && (din[7:5] == CMD_EOS_ANY);
        eos_one   = is_cmd2 && (din[7:5] == CMD_EOS_ONE);
        eos_lvl   = din[LVL_W-1:0];
        poll_stb  = is_cmd3 && din[2];
    end

    // Start-up sequence and programmed registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= INIT_WAIT_START;
            want_extra <= 1'b0;
            level_mode <= 1'b0;
            vec_base   <= '0;
            mask       <= '0;
            stat_sel   <= SEL_PEND;
        end else if (start_stb) begin
            state      <= INIT_WAIT_BASE;
            want_extra <= din[0];
            level_mode <= din[3];
            mask       <= '0;
            stat_sel   <= SEL_PEND;
        end else if (wr_stb && a0) begin
            case (state)
                INIT_WAIT_BASE: begin
                    vec_base <= din[DATA_W-1:LVL_W];
                    state    <= want_extra ? INIT_WAIT_EXTRA : INIT_READY;
                end
                INIT_WAIT_EXTRA: state <= INIT_READY;
                INIT_READY:      mask  <= din[N_IRQ-1:0];
                default:         state <= state;
            endcase
        end else if (is_cmd3 && din[1]) begin
            stat_sel <= din[0] ? SEL_SERV : SEL_PEND;
        end
    end

    p_start_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> (state == INIT_WAIT_BASE && mask == '0));
    p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_stb && a0) |=> (mask == $past(din[N_IRQ-1:0])));
endmodule

// File: rtl/irq_vec_ctrl.sv
// Vectored priority interrupt controller top. Holds the in-service set, the
// two-pulse acknowledge sequencer and the poll result, and muxes read data.
// Assumes synchronous active-low strobes, one access per low cycle.
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic [N_IRQ-1:0]  irq,
    input  logic              inta_n,
    output logic              int_o
);
    localparam int LVL_W  = $clog2(N_IRQ);
    localparam int BASE_W = DATA_W - LVL_W;
    localparam int PAD_W  = DATA_W - 1 - LVL_W;

    logic              wr_stb, rd_stb, ack_stb;
    logic              ready, level_mode;
    logic [BASE_W-1:0] vec_base;
    logic [N_IRQ-1:0]  mask, pend, serv;
    stat_sel_t         stat_sel;
    logic              start_stb, eos_any, eos_one, poll_stb;
    logic [LVL_W-1:0]  eos_lvl;
    logic              grant_valid, serv_valid;
    logic [LVL_W-1:0]  grant_lvl, serv_lvl;
    logic              grant_ok, ack_first, ack_second, take;
    logic [N_IRQ-1:0]  set_mask, clr_mask;
    logic              ack_phase, frz_valid, poll_pend;
    logic [LVL_W-1:0]  frz_lvl;
    logic [DATA_W-1:0] poll_word;

    // Strobe qualification
    always_comb begin
        wr_stb  = !cs_n && !wr_n;
        rd_stb  = !cs_n && !rd_n;
        ack_stb = !inta_n;
    end

    irq_host_port #(.N_IRQ(N_IRQ)) u_port (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .a0(a0), .din(din),
        .ready(ready), .level_mode(level_mode), .vec_base(vec_base),
        .mask(mask), .stat_sel(stat_sel), .start_stb(start_stb),
        .eos_any(eos_any), .eos_one(eos_one), .eos_lvl(eos_lvl),
        .poll_stb(poll_stb)
    );

    irq_req_latch #(.N_IRQ(N_IRQ)) u_latch (
        .clk(clk), .rst_n(rst_n), .irq(irq), .level_mode(level_mode),
        .clear_all(start_stb), .take_mask(set_mask), .eos_mask(clr_mask),
        .pend(pend)
    );

    irq_prio_resolve #(.N_IRQ(N_IRQ)) u_prio (
        .pend(pend), .mask(mask), .serv(serv),
        .grant_valid(grant_valid), .grant_lvl(grant_lvl),
        .serv_valid(serv_valid), .serv_lvl(serv_lvl)
    );

    // Grant, service set and service clear masks
    always_comb begin
        grant_ok   = ready && grant_valid;
        ack_first  = ack_stb && !ack_phase;
        ack_second = ack_stb && ack_phase;
        take       = (ack_first || poll_stb) && grant_ok;
        set_mask   = take ? (N_IRQ'(1) << grant_lvl) : '0;
        if (eos_any && serv_valid) clr_mask = N_IRQ'(1) << serv_lvl;
        else if (eos_one)          clr_mask = N_IRQ'(1) << eos_lvl;
        else                       clr_mask = '0;
        int_o = grant_ok;
    end

    // In-service register
    always_ff @(posedge clk) begin
        if (!rst_n || start_stb) serv <= '0;
        else                     serv <= (serv & ~clr_mask) | set_mask;
    end

    // Acknowledge sequencer: freeze winner on first pulse, release on second
    always_ff @(posedge clk) begin
        if (!rst_n || start_stb) begin
            ack_phase <= 1'b0;
            frz_valid <= 1'b0;
            frz_lvl   <= '0;
        end else if (ack_first) begin
            ack_phase <= 1'b1;
            frz_valid <= grant_ok;
            frz_lvl   <= grant_lvl;
        end else if (ack_second) begin
            ack_phase <= 1'b0;
            frz_valid <= 1'b0;
        end
    end

    // Poll result held until the next address-0 read
    always_ff @(posedge clk) begin
        if (!rst_n || start_stb) begin
            poll_pend <= 1'b0;
            poll_word <= '0;
        end else if (poll_stb) begin
            poll_pend <= 1'b1;
            poll_word <= grant_ok ? {1'b1, {PAD_W{1'b0}}, grant_lvl} : '0;
        end else if (rd_stb && !a0) begin
            poll_pend <= 1'b0;
        end
    end

    // Output data mux: vector, poll result, status or mask
    always_comb begin
        dout    = '0;
        dout_oe = 1'b0;
        if (ack_second) begin
            dout_oe = frz_valid;
            dout    = frz_valid ? {vec_base, frz_lvl} : '0;
        end else if (rd_stb) begin
            dout_oe = 1'b1;
            if (a0)                       dout = DATA_W'(mask);
            else if (poll_pend)           dout = poll_word;
            else if (stat_sel == SEL_SERV) dout = DATA_W'(serv);
            else                          dout = DATA_W'(pend);
        end
    end

    p_ack_marks_serv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_first && grant_ok) |=> serv[frz_lvl]);
    p_idle_ack_keeps_serv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_first && !grant_ok && !wr_stb) |=> (serv == $past(serv)));
    p_eos_any_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_any && serv != '0 && !take) |=> ($countones(serv) + 1 == $countones($past(serv))));
    p_eos_one_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_one && !take) |=> !serv[$past(eos_lvl)]);
    p_poll_marks_serv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_stb && grant_ok && !ack_stb) |=> (poll_word[7] && serv[poll_word[LVL_W-1:0]]));
endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_WR   = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_IRQ  = 3'd2;
    localparam logic [2:0] OP_INT  = 3'd3;
    localparam logic [2:0] OP_ACK1 = 3'd4;
    localparam logic [2:0] OP_ACK2 = 3'd5;

    // {op[24:22], a0[21], data[20:13], expect[12:4] (bit 8 = oe), req[3:0]}
    localparam int NV = 66;
    localparam logic [24:0] TBL [0:NV-1] = '{
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd1},   // R1 low after reset
        {OP_RD,  1'b1, 8'h00, 9'h000, 4'd1},   // R1 mask reads zero
        {OP_WR,  1'b0, 8'h11, 9'h000, 4'd1},   // R1 start, edge, extra word
        {OP_WR,  1'b1, 8'h40, 9'h000, 4'd1},   // R1 base 0x40
        {OP_IRQ, 1'b0, 8'h04, 9'h000, 4'd2},   // line 2 rises
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd1},   // R1 held low mid-sequence
        {OP_WR,  1'b1, 8'hFF, 9'h000, 4'd1},   // R1 extra word, not a mask
        {OP_INT, 1'b0, 8'h00, 9'h001, 4'd2},   // R2 pending level 2
        {OP_WR,  1'b1, 8'hFF, 9'h000, 4'd2},   // R2 mask all
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd2},   // R2 masked
        {OP_ACK1,1'b0, 8'h00, 9'h000, 4'd5},
        {OP_ACK2,1'b0, 8'h00, 9'h000, 4'd5},   // R5 no vector
        {OP_WR,  1'b0, 8'h0B, 9'h000, 4'd10},  // R10 select service set
        {OP_RD,  1'b0, 8'h00, 9'h000, 4'd5},   // R5 nothing in service
        {OP_WR,  1'b1, 8'h00, 9'h000, 4'd2},   // unmask
        {OP_IRQ, 1'b0, 8'h00, 9'h000, 4'd2},   // line drops
        {OP_INT, 1'b0, 8'h00, 9'h001, 4'd2},   // R2 still latched
        {OP_RD,  1'b1, 8'h00, 9'h000, 4'd10},  // R10 mask readback
        {OP_WR,  1'b0, 8'h0A, 9'h000, 4'd10},  // R10 select pending set
        {OP_RD,  1'b0, 8'h00, 9'h004, 4'd10},  // R10 pending = level 2
        {OP_ACK1,1'b0, 8'h00, 9'h000, 4'd4},
        {OP_ACK2,1'b0, 8'h00, 9'h142, 4'd4},   // R4 vector 0x42
        {OP_RD,  1'b0, 8'h00, 9'h000, 4'd4},   // R4 edge latch cleared
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd4},
        {OP_WR,  1'b0, 8'h0B, 9'h000, 4'd10},
        {OP_RD,  1'b0, 8'h00, 9'h004, 4'd4},   // R4 level 2 in service
        {OP_IRQ, 1'b0, 8'h20, 9'h000, 4'd3},
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd3},   // R3 level 5 blocked by 2
        {OP_IRQ, 1'b0, 8'h21, 9'h000, 4'd3},
        {OP_INT, 1'b0, 8'h00, 9'h001, 4'd3},   // R3 level 0 pre-empts
        {OP_ACK1,1'b0, 8'h00, 9'h000, 4'd3},
        {OP_ACK2,1'b0, 8'h00, 9'h140, 4'd3},   // R3 vector 0x40
        {OP_RD,  1'b0, 8'h00, 9'h005, 4'd3},   // R3 nested service
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd3},
        {OP_WR,  1'b0, 8'h20, 9'h000, 4'd6},   // R6 end any
        {OP_RD,  1'b0, 8'h00, 9'h004, 4'd6},   // R6 level 0 retired
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd6},
        {OP_WR,  1'b0, 8'h62, 9'h000, 4'd7},   // R7 end level 2
        {OP_RD,  1'b0, 8'h00, 9'h000, 4'd7},
        {OP_INT, 1'b0, 8'h00, 9'h001, 4'd7},
        {OP_WR,  1'b0, 8'h0C, 9'h000, 4'd9},   // R9 poll
        {OP_RD,  1'b0, 8'h00, 9'h085, 4'd9},   // R9 level 5 granted
        {OP_RD,  1'b0, 8'h00, 9'h020, 4'd9},   // R9 back to status
        {OP_IRQ, 1'b0, 8'h00, 9'h000, 4'd9},
        {OP_WR,  1'b0, 8'h65, 9'h000, 4'd7},   // R7 end level 5
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd7},
        {OP_WR,  1'b0, 8'h0C, 9'h000, 4'd9},   // R9 empty poll
        {OP_RD,  1'b0, 8'h00, 9'h000, 4'd9},
        {OP_WR,  1'b1, 8'h5A, 9'h000, 4'd10},
        {OP_RD,  1'b1, 8'h00, 9'h05A, 4'd10},  // R10 mask
        {OP_WR,  1'b0, 8'h18, 9'h000, 4'd1},   // R1 restart, level, no extra
        {OP_RD,  1'b1, 8'h00, 9'h000, 4'd1},   // R1 mask cleared
        {OP_WR,  1'b1, 8'h80, 9'h000, 4'd1},   // base 0x80
        {OP_IRQ, 1'b0, 8'h08, 9'h000, 4'd8},
        {OP_INT, 1'b0, 8'h00, 9'h001, 4'd8},
        {OP_ACK1,1'b0, 8'h00, 9'h000, 4'd8},
        {OP_ACK2,1'b0, 8'h00, 9'h183, 4'd8},   // R8 vector 0x83
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd8},
        {OP_WR,  1'b0, 8'h20, 9'h000, 4'd8},   // end while held
        {OP_INT, 1'b0, 8'h00, 9'h001, 4'd8},   // R8 requests again
        {OP_ACK1,1'b0, 8'h00, 9'h000, 4'd8},
        {OP_ACK2,1'b0, 8'h00, 9'h183, 4'd8},
        {OP_IRQ, 1'b0, 8'h00, 9'h000, 4'd8},
        {OP_WR,  1'b0, 8'h20, 9'h000, 4'd8},   // end after line low
        {OP_INT, 1'b0, 8'h00, 9'h000, 4'd8},
        {OP_RD,  1'b0, 8'h00, 9'h000, 4'd8}    // R8 pending cleared
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] irq = '0;
    logic       inta_n = 1'b1;
    logic       int_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vec_ctrl u_irq_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .din(din), .dout(dout), .dout_oe(dout_oe), .irq(irq),
        .inta_n(inta_n), .int_o(int_o)
    );

    task automatic check(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [24:0] e);
        logic [2:0] op;
        int         req;
        op  = e[24:22];
        req = int'(e[3:0]);
        @(negedge clk);
        case (op)
            OP_WR:   begin cs_n = 1'b0; wr_n = 1'b0; a0 = e[21]; din = e[20:13]; end
            OP_RD:   begin cs_n = 1'b0; rd_n = 1'b0; a0 = e[21]; end
            OP_IRQ:  irq = e[20:13];
            OP_ACK1, OP_ACK2: inta_n = 1'b0;
            default: ;
        endcase
        #1;
        case (op)
            OP_INT: check(req, "int_o", int'(int_o), int'(e[4]));
            OP_RD: begin
                check(req, "read oe", int'(dout_oe), 1);
                check(req, "read data", int'(dout), int'(e[11:4]));
            end
            OP_ACK2: begin
                check(req, "vector oe", int'(dout_oe), int'(e[12]));
                if (e[12]) check(req, "vector", int'(dout), int'(e[11:4]));
            end
            default: ;
        endcase
        @(posedge clk);
        #1;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) run_op(TBL[k]);

        // Directed: reset mid-run with a line held (R1)
        @(negedge clk);
        irq = 8'h01;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check(1, "int_o after reset, uninitialized", int'(int_o), 0);  // R1
        check(1, "dout_oe idle after reset", int'(dout_oe), 0);        // R1
        run_op({OP_RD, 1'b1, 8'h00, 9'h000, 4'd1});                     // R1 mask zero
        // Directed: acknowledge before initialization gives no vector (R5)
        run_op({OP_ACK1, 1'b0, 8'h00, 9'h000, 4'd5});
        run_op({OP_ACK2, 1'b0, 8'h00, 9'h000, 4'd5});
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule